// File: doc/BRIEF.md
# Digital Third-Order Cascaded Noise-Shaping Modulator

This block turns a wide unsigned fractional word into a short signed code stream whose long-run average equals the input divided by 2^N. Three first-order accumulator stages sit in a chain. The first stage accumulates the input. Each later stage accumulates the wrapped residue that the stage before it keeps. Each stage emits its overflow carry as a one-bit code.

A cancellation network combines the three carries. The first carry is delayed by two steps. The second carry is delayed once and differenced once. The third carry is differenced twice. In the sum, the error of each early stage is removed by the stage after it, and only the last stage's error remains, shaped to third order. Every stage is first order, so the loop cannot go unstable for any input.

Typical uses are fractional-N divider control and a digital front end that drives a few-level DAC. A clock enable freezes every register while low. A synchronous reset clears all of them.

Top module: `mash111_mod`

## Requirements
- R1: On each enabled edge, stage 1 replaces its accumulator with (accumulator + x_in) mod 2^N. Its carry for that step is 1 exactly when the unwrapped sum reaches 2^N.
- R2: On each enabled edge, stage 2 adds stage 1's accumulator value from before the edge, and stage 3 adds stage 2's value from before the edge. Both wrap mod 2^N and produce carries as in R1.
- R3: Count enabled steps with n, and take carries from before reset as 0. The value loaded into y_out at step n is c1[n-2] + c2[n-1] - c2[n-2] + c3[n] - 2*c3[n-1] + c3[n-2].
- R4: y_out is 4-bit two's complement and always lies between -3 and +4.
- R5: An input word sampled at enabled step k cannot change the y_out loaded at step k or at step k+1. Its earliest possible effect is at step k+2.
- R6: A clock edge with rst high clears all accumulators, carry history and y_out to zero, whatever the value of en.
- R7: With en low and rst low, x_in is ignored and no register changes, so y_out holds. When en returns high, the output sequence continues as if the disabled edges had not occurred.
- R8: Hold a constant input k long enough that the two-step alignment has filled. Any 2^N consecutive outputs after that sum to within 3 of k.
- R9: The extreme inputs 0 and 2^N-1 follow R1 to R3 exactly. With input 0, the summed output over a 2^N window stays within 3 of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, overrides en |
| en | input | 1 | Clock enable; low freezes all state |
| x_in | input | N | Unsigned fractional input word |
| y_out | output | 4 | Signed output code, registered |

## Verification
The bench builds the modulator with N = 8, so the modulus is 256. A full averaging window of 2^N outputs then fits many times within the run. The wrap of every stage, including the all-ones input, occurs within a few hundred cycles. At this width the exact cycle-by-cycle model catches any misalignment in the carry delays or the differencing weights. Reset and enable can also be toggled in the middle of accumulator wrap sequences that would take tens of thousands of cycles to reach at the default width.

// File: rtl/mash_pkg.sv
package mash_pkg;
   // number of cascaded first-order stages
   localparam int STAGES = 3;
   // alignment depth of the cancellation network (order of the last stage)
   localparam int ALIGN  = STAGES - 1;
   // output code width: range -3..+4 needs four bits
   localparam int OUT_W  = 4;
   typedef logic signed [OUT_W-1:0] mash_code_t;
endpackage

// File: rtl/mash_acc_stage.sv
module mash_acc_stage #(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [N-1:0] in_word,
   output logic         carry,
   output logic [N-1:0] resid
);
   localparam int SUM_W = N + 1;

   logic [SUM_W-1:0] sum;
   logic [N-1:0]     acc_q;

   // carry belongs to the update taking place at the coming edge
   assign sum   = {1'b0, acc_q} + {1'b0, in_word};
   assign carry = sum[N];
   assign resid = acc_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
      end else if (en) begin
         acc_q <= sum[N-1:0];
      end
   end

   // R1: an overflow leaves a wrapped value below the word that was added
   a_r1_wrap_below_input: assert property (@(posedge clk) disable iff (rst)
      (en && carry) |=> (acc_q < $past(in_word)));

   // R1: without an overflow the accumulator cannot decrease
   a_r1_no_wrap_grows: assert property (@(posedge clk) disable iff (rst)
      (en && !carry) |=> (acc_q >= $past(acc_q)));

   // R7: a disabled edge leaves the accumulator untouched
   a_r7_stage_frozen: assert property (@(posedge clk) disable iff (rst)
      (!en) |=> $stable(acc_q));
endmodule

// File: rtl/mash_carry_taps.sv
module mash_carry_taps #(
   parameter int DEPTH = 2,
   parameter int FIRST = 0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               en,
   input  logic               d,
   output logic [DEPTH-FIRST:0] taps
);
   logic [DEPTH-1:0] hist_q;
   logic [DEPTH:0]   line;

   generate
      if (DEPTH < 1 || FIRST < 0 || FIRST > DEPTH) begin : g_bad_cfg
         $error("mash_carry_taps: need DEPTH >= 1 and 0 <= FIRST <= DEPTH");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         hist_q <= '0;
      end else if (en) begin
         hist_q[0] <= d;
         for (int j = 1; j < DEPTH; j++) begin
            hist_q[j] <= hist_q[j-1];
         end
      end
   end

   // line[0] is the current carry, line[j] the carry j enabled steps ago
   assign line = {hist_q, d};
   assign taps = line[DEPTH:FIRST];
endmodule

// File: rtl/mash_diff_net.sv
module mash_diff_net
   import mash_pkg::*;
#(
   parameter int ORDER = 0
) (
   input  logic [ORDER:0] taps,
   output mash_code_t     value
);
   generate
      if (ORDER == 0) begin : g_pass
         assign value = mash_code_t'({3'b000, taps[0]});
      end else if (ORDER == 1) begin : g_first
         mash_code_t t0, t1;
         assign t0    = mash_code_t'({3'b000, taps[0]});
         assign t1    = mash_code_t'({3'b000, taps[1]});
         assign value = t0 - t1;
      end else if (ORDER == 2) begin : g_second
         mash_code_t t0, t1, t2;
         assign t0    = mash_code_t'({3'b000, taps[0]});
         assign t1    = mash_code_t'({2'b00, taps[1], 1'b0});
         assign t2    = mash_code_t'({3'b000, taps[2]});
         assign value = t0 - t1 + t2;
      end else begin : g_bad_order
         $error("mash_diff_net: ORDER must be 0, 1 or 2");
         assign value = '0;
      end
   endgenerate
endmodule

// File: rtl/mash111_mod.sv
module mash111_mod
   import mash_pkg::*;
#(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [N-1:0] x_in,
   output logic [3:0]   y_out
);
   generate
      if (N < 2 || N > 30) begin : g_bad_width
         $error("mash111_mod: N must lie in 2..30");
      end
      if (OUT_W != 4) begin : g_bad_out
         $error("mash111_mod: output code must be four bits");
      end
   endgenerate

   logic [N-1:0] stage_in [STAGES];
   logic [N-1:0] resid    [STAGES];
   logic         carry    [STAGES];
   mash_code_t   contrib  [STAGES];
   mash_code_t   y_next;
   mash_code_t   y_q;

   assign stage_in[0] = x_in;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i > 0) begin : g_chain
            assign stage_in[i] = resid[i-1];
         end

         mash_acc_stage #(.N(N)) u_acc (
            .clk    (clk),
            .rst    (rst),
            .en     (en),
            .in_word(stage_in[i]),
            .carry  (carry[i]),
            .resid  (resid[i])
         );

         // stage i: delayed by ALIGN-i, then differenced i times
         logic [i:0] tp;

         mash_carry_taps #(.DEPTH(ALIGN), .FIRST(ALIGN - i)) u_taps (
            .clk (clk),
            .rst (rst),
            .en  (en),
            .d   (carry[i]),
            .taps(tp)
         );

         mash_diff_net #(.ORDER(i)) u_diff (
            .taps (tp),
            .value(contrib[i])
         );
      end
   endgenerate

   always_comb begin
      y_next = '0;
      for (int i = 0; i < STAGES; i++) begin
         y_next = y_next + contrib[i];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         y_q <= '0;
      end else if (en) begin
         y_q <= y_next;
      end
   end

   assign y_out = y_q;

   // R4: output code stays inside -3..+4
   a_r4_code_range: assert property (@(posedge clk) disable iff (rst)
      (($signed(y_q) >= -3) && ($signed(y_q) <= 4)));

   // R6: a reset edge zeroes the output and every accumulator
   a_r6_reset_clears: assert property (@(posedge clk)
      rst |=> ((y_q == '0) && (resid[0] == '0) && (resid[1] == '0) && (resid[2] == '0)));

   // R7: a disabled edge leaves the output unchanged
   a_r7_output_hold: assert property (@(posedge clk) disable iff (rst)
      (!en) |=> $stable(y_q));

   // R2: a disabled edge also freezes the residue that feeds the next stage
   a_r2_chain_frozen: assert property (@(posedge clk) disable iff (rst)
      (!en) |=> ($stable(resid[0]) && $stable(resid[1])));

   // R3: with no carry anywhere, now or in the two previous steps, the output is zero
   a_r3_quiet_output: assert property (@(posedge clk) disable iff (rst)
      (en && !carry[0] && !carry[1] && !carry[2] && (y_next == '0)) |=> (y_q == '0));
endmodule

// File: tb/sim_mash111_mod.sv
module sim_mash111_mod;
   localparam int N = 8;
   localparam int M = 1 << N;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic         rst;
   logic         en;
   logic [N-1:0] x;
   logic [3:0]   y;

   mash111_mod #(.N(N)) u0 (
      .clk  (clk),
      .rst  (rst),
      .en   (en),
      .x_in (x),
      .y_out(y)
   );

   typedef struct {
      int    val;
      string tag;
   } exp_t;

   exp_t sb[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   // reference state, kept from the requirement equations
   int a1, a2, a3, h1a, h1b, h2a, h2b, h3a, h3b, yhold;
   logic [15:0] lf = 16'hACE1;

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   task automatic adv_lfsr();
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
   endtask

   // driver: applies one edge of stimulus and queues the predicted output
   task automatic step(input bit r, input bit e, input int xv, input string tag);
      exp_t it;
      int s1, s2, s3, c1, c2, c3;
      @(negedge clk);
      rst = r;
      en  = e;
      x   = xv[N-1:0];
      if (r) begin
         a1 = 0; a2 = 0; a3 = 0;
         h1a = 0; h1b = 0; h2a = 0; h2b = 0; h3a = 0; h3b = 0;
         yhold = 0;
      end else if (e) begin
         s1 = a1 + (xv % M);
         s2 = a2 + a1;
         s3 = a3 + a2;
         c1 = (s1 >= M) ? 1 : 0;
         c2 = (s2 >= M) ? 1 : 0;
         c3 = (s3 >= M) ? 1 : 0;
         yhold = h1b + h2a - h2b + c3 - 2 * h3a + h3b;
         a1 = s1 % M; a2 = s2 % M; a3 = s3 % M;
         h1b = h1a; h1a = c1;
         h2b = h2a; h2a = c2;
         h3b = h3a; h3a = c3;
      end
      it.val = yhold;
      it.tag = tag;
      sb.push_back(it);
      @(posedge clk);
      #1;
   endtask

   // monitor: compares each produced output against the queue head
   initial begin
      exp_t it;
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            it = sb.pop_front();
            chk($signed(y) == it.val, it.tag, $signed(y), it.val);
            // R4: every code stays in -3..+4
            chk(($signed(y) >= -3) && ($signed(y) <= 4), "R4", $signed(y), 0);
         end
      end
   end

   task automatic mean_run(input int k, input string tag);
      int sum;
      for (int i = 0; i < 20; i++) step(1'b0, 1'b1, k, "R1");
      sum = 0;
      for (int i = 0; i < M; i++) begin
         step(1'b0, 1'b1, k, "R3");
         sum += $signed(y);
      end
      chk((sum >= k - 3) && (sum <= k + 3), tag, sum, k);
   endtask

   initial begin
      rst = 1'b1;
      en  = 1'b0;
      x   = '0;
      a1 = 0; a2 = 0; a3 = 0;
      h1a = 0; h1b = 0; h2a = 0; h2b = 0; h3a = 0; h3b = 0;
      yhold = 0;

      // R6: reset state
      for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 55, "R6");
      chk($signed(y) == 0, "R6", $signed(y), 0);

      // R5: a large word cannot reach the output for two steps
      for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 0, "R5");
      step(1'b0, 1'b1, M - 1, "R5");
      chk($signed(y) == 0, "R5", $signed(y), 0);
      step(1'b0, 1'b1, M - 1, "R5");
      chk($signed(y) == 0, "R5", $signed(y), 0);

      // R1, R3, R8: constant inputs and their long-run mean
      mean_run(77, "R8");
      mean_run(200, "R8");
      // R9: extremes
      mean_run(M - 1, "R9");
      mean_run(0, "R9");

      // R2: varying input pattern through the whole chain
      for (int i = 0; i < 600; i++) begin
         adv_lfsr();
         step(1'b0, 1'b1, int'(lf[7:0]), "R2");
      end

      // R7: explicit freeze with changing input
      begin
         int held;
         held = $signed(y);
         for (int i = 0; i < 5; i++) begin
            adv_lfsr();
            step(1'b0, 1'b0, int'(lf[7:0]), "R7");
         end
         chk($signed(y) == held, "R7", $signed(y), held);
      end

      // R7: irregular enable pattern
      for (int i = 0; i < 500; i++) begin
         adv_lfsr();
         step(1'b0, lf[0] | lf[3], int'(lf[15:8]), "R7");
      end

      // R6: reset wins over a low enable
      step(1'b1, 1'b0, 99, "R6");
      chk($signed(y) == 0, "R6", $signed(y), 0);
      for (int i = 0; i < 80; i++) begin
         adv_lfsr();
         step(1'b0, 1'b1, int'(lf[11:4]), "R3");
      end

      step(1'b0, 1'b0, 0, "R7");
      @(posedge clk);
      #2;
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule